// File: doc/BRIEF.md
# Line Zero-Crossing Detector with Sag Timeout

This block watches a stream of signed, already filtered line-voltage samples that arrive with a valid strobe. It drives a square wave whose level follows the polarity of the latest sample, so the wave rises when the line goes from negative to non-negative and falls on the opposite transition. A 12-bit down-counter measures how long the line has gone without a crossing. The counter steps once every 128 clock cycles and is reloaded with a programmed value on every detected crossing.

When the counter runs out, the block latches a timeout status flag and pulls an active-low sag output low, unless a control bit disables that pin. It raises an active-low interrupt only when that flag's enable bit is set. Crossings set a second status flag, which can also be enabled onto the interrupt. A small register port gives access to the timeout value, the sag-disable control, the interrupt enables, and two views of the status flags: a plain view, and a view that clears the flags when read.

Top module: `zc_sag_monitor`

## Requirements
- R1: After reset, zx is 0, sag_n and irq_n are 1, both status flags are 0, and the timeout register at address 0x1D reads 0xFFF.
- R2: zx takes the polarity of each valid sample: 1 for a value of zero or more, 0 for a negative value. Cycles with smp_valid low leave zx unchanged. A crossing is a polarity change between two consecutive valid samples.
- R3: The timeout register at address 0x1D holds 12 bits and is both writable and readable. Write-data bits above bit 11 are dropped and read back as 0.
- R4: A crossing reloads the counter with the programmed value N and restarts the 128-cycle prescaler. If no further crossing arrives, sag_n goes low exactly 128*N clock edges after the crossing edge, for N of 1 or more. A crossing that arrives before then restarts the full interval.
- R5: After a timeout, sag_n stays low until the next crossing, and returns high on that crossing's clock edge.
- R6: With bit 0 of the control register (address 0x0F) set, sag_n stays high through a timeout while the timeout flag is still set. Clearing that bit while timed out drives sag_n low.
- R7: A timeout sets status bit 1 whatever its enable. irq_n goes low for it only when bit 1 of the enable register (address 0x0A) is 1.
- R8: A crossing sets status bit 0. irq_n goes low for it only when bit 0 of the enable register is 1.
- R9: A read of address 0x0C returns the status flags and clears them on that clock edge, which releases irq_n. A read of address 0x0B returns the same flags without clearing them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new sample |
| smp_data | input | 16 | Signed filtered voltage sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| zx | output | 1 | Zero-crossing square wave |
| sag_n | output | 1 | Active-low loss-of-crossing indicator |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench measures the timeout to the exact clock edge. It checks one cycle before expiry and one cycle after, so a design that is off by one prescaler step or one clock fails. It sends a sample of exactly zero to catch designs that treat zero as negative. It sends invalid strobes carrying negative data to catch a detector that does not gate on the strobe. It restarts the count partway through to catch a reload that keeps the old prescaler phase. Masked interrupts, the sag-disable bit, and the difference between the clearing and non-clearing status reads are each driven directly, because a design that mixes up these controls would lose a flag or assert a pin it should not.

// File: rtl/zcsm_pkg.sv
package zcsm_pkg;

   // status flags as seen on the register port: bit 1 timeout, bit 0 crossing
   typedef struct packed {
      logic tmo;
      logic xing;
   } zcsm_flags_t;

   localparam int unsigned ZCSM_FLAG_W = $bits(zcsm_flags_t);

endpackage

// File: rtl/zcsm_polarity.sv
module zcsm_polarity #(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   output logic                       zx,
   output logic                       xing
);

   logic pol_q;
   logic seen_q;
   logic now_pos;

   // zero counts as positive
   assign now_pos = ~smp_data[SAMPLE_W-1];
   assign xing    = smp_valid & seen_q & (now_pos != pol_q);
   assign zx      = pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= 1'b0;
         seen_q <= 1'b0;
      end else if (smp_valid) begin
         pol_q  <= now_pos;
         seen_q <= 1'b1;
      end
   end

   p_zx_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(zx));

endmodule

// File: rtl/zcsm_tick.sv
module zcsm_tick #(
   parameter int unsigned DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_direct
         assign tick = ~restart;
      end else begin : g_count
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pc_q;

         assign tick = (pc_q == LAST) & ~restart;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_q <= '0;
            end else if (restart || pc_q == LAST) begin
               pc_q <= '0;
            end else begin
               pc_q <= pc_q + 1'b1;
            end
         end

         p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (pc_q == '0));
      end
   endgenerate

endmodule

// File: rtl/zcsm_watchdog.sv
module zcsm_watchdog #(
   parameter int unsigned TMO_W     = 12,
   parameter int unsigned TMO_RESET = 12'hFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [TMO_W-1:0] reload_val,
   input  logic             tick,
   output logic             expired,
   output logic             expire_evt
);

   localparam logic [TMO_W-1:0] CNT_INIT = TMO_W'(TMO_RESET);

   logic [TMO_W-1:0] cnt_q;
   logic             last_step;

   assign last_step  = (cnt_q <= TMO_W'(1));
   assign expire_evt = tick & ~reload & ~expired & last_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= CNT_INIT;
         expired <= 1'b0;
      end else if (reload) begin
         cnt_q   <= reload_val;
         expired <= 1'b0;
      end else begin
         if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
         if (expire_evt) begin
            expired <= 1'b1;
         end
      end
   end

   p_hold_expired_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !reload) |=> expired);

   p_reload_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (!expired && cnt_q == $past(reload_val)));

   p_step_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reload) |=> $stable(cnt_q));

endmodule

// File: rtl/zcsm_regs.sv
module zcsm_regs
   import zcsm_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned TMO_W     = 12,
   parameter int unsigned TMO_RESET = 12'hFFF,
   parameter int unsigned A_TMO     = 6'h1D,
   parameter int unsigned A_CTRL    = 6'h0F,
   parameter int unsigned A_IRQEN   = 6'h0A,
   parameter int unsigned A_STAT    = 6'h0B,
   parameter int unsigned A_STATRC  = 6'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              xing_evt,
   input  logic              tmo_evt,
   output logic [TMO_W-1:0]  tmo_val,
   output logic              sag_off,
   output zcsm_flags_t       flags,
   output zcsm_flags_t       irq_en
);

   localparam logic [ADDR_W-1:0] AD_TMO   = ADDR_W'(A_TMO);
   localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_IRQEN = ADDR_W'(A_IRQEN);
   localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] AD_STRC  = ADDR_W'(A_STATRC);

   logic        clr_rd;
   zcsm_flags_t flags_nx;
   logic        unused_wdata;

   assign unused_wdata = ^reg_wdata;
   assign clr_rd       = reg_rd & (reg_addr == AD_STRC);

   // a new event in the clearing cycle survives the clear
   always_comb begin
      flags_nx      = clr_rd ? '0 : flags;
      flags_nx.xing = flags_nx.xing | xing_evt;
      flags_nx.tmo  = flags_nx.tmo  | tmo_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_val <= TMO_W'(TMO_RESET);
         sag_off <= 1'b0;
         irq_en  <= '0;
         flags   <= '0;
      end else begin
         flags <= flags_nx;
         if (reg_wr) begin
            unique case (reg_addr)
               AD_TMO:   tmo_val <= reg_wdata[TMO_W-1:0];
               AD_CTRL:  sag_off <= reg_wdata[0];
               AD_IRQEN: irq_en  <= reg_wdata[ZCSM_FLAG_W-1:0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (reg_addr)
         AD_TMO:           reg_rdata = DATA_W'(tmo_val);
         AD_CTRL:          reg_rdata = DATA_W'(sag_off);
         AD_IRQEN:         reg_rdata = DATA_W'(irq_en);
         AD_STAT, AD_STRC: reg_rdata = DATA_W'(flags);
         default:          reg_rdata = '0;
      endcase
   end

   p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rd && !xing_evt && !tmo_evt) |=> (flags == '0));

   p_tmo_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.tmo && !clr_rd) |=> flags.tmo);

endmodule

// File: rtl/zc_sag_monitor.sv
module zc_sag_monitor
   import zcsm_pkg::*;
#(
   parameter int unsigned SAMPLE_W  = 16,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned TMO_W     = 12,
   parameter int unsigned TMO_RESET = 12'hFFF,
   parameter int unsigned PRESCALE  = 128
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_data,
   input  logic                       reg_wr,
   input  logic                       reg_rd,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic                       zx,
   output logic                       sag_n,
   output logic                       irq_n
);

   generate
      if (TMO_W > DATA_W) begin : g_bad_width
         $error("timeout width exceeds register data width");
      end
      if (PRESCALE < 1) begin : g_bad_div
         $error("prescale must be at least 1");
      end
      if (TMO_RESET >= (1 << TMO_W)) begin : g_bad_reset
         $error("timeout reset value does not fit");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("address width too small for register map");
      end
   endgenerate

   logic             xing;
   logic             tick;
   logic             expired;
   logic             expire_evt;
   logic [TMO_W-1:0] tmo_val;
   logic             sag_off;
   zcsm_flags_t      flags;
   zcsm_flags_t      irq_en;

   zcsm_polarity #(.SAMPLE_W(SAMPLE_W)) u_pol (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .zx        (zx),
      .xing      (xing)
   );

   zcsm_tick #(.DIV(PRESCALE)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (xing),
      .tick    (tick)
   );

   zcsm_watchdog #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_wd (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload     (xing),
      .reload_val (tmo_val),
      .tick       (tick),
      .expired    (expired),
      .expire_evt (expire_evt)
   );

   zcsm_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .TMO_W     (TMO_W),
      .TMO_RESET (TMO_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .xing_evt  (xing),
      .tmo_evt   (expire_evt),
      .tmo_val   (tmo_val),
      .sag_off   (sag_off),
      .flags     (flags),
      .irq_en    (irq_en)
   );

   assign sag_n = ~(expired & ~sag_off);
   assign irq_n = ~|(flags & irq_en);

   p_sag_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sag_n) && !$past(reg_wr) |-> flags.tmo);

endmodule

// File: tb/sim_zc_sag_monitor.sv
module sim_zc_sag_monitor;

   localparam logic [5:0] AD_TMO   = 6'h1D;
   localparam logic [5:0] AD_CTRL  = 6'h0F;
   localparam logic [5:0] AD_IRQEN = 6'h0A;
   localparam logic [5:0] AD_STAT  = 6'h0B;
   localparam logic [5:0] AD_STRC  = 6'h0C;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_valid = 1'b0;
   logic signed [15:0] smp_data = '0;
   logic               reg_wr = 1'b0;
   logic               reg_rd = 1'b0;
   logic [5:0]         reg_addr = '0;
   logic [15:0]        reg_wdata = '0;
   logic [15:0]        reg_rdata;
   logic               zx;
   logic               sag_n;
   logic               irq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   zc_sag_monitor u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .zx(zx), .sag_n(sag_n), .irq_n(irq_n)
   );

   function automatic logic pol_of(input logic signed [15:0] v);
      return (v >= 0);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic signed [15:0] v);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = v;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      reg_rd   = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd   = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic exp_pol;
      logic exp_xing;
      void'($urandom(32'd2024));
      idle(3);
      // R1 reset state
      chk("R1 zx", zx, 0);
      chk("R1 sag_n", sag_n, 1);
      chk("R1 irq_n", irq_n, 1);
      rd(AD_TMO, d);  chk("R1 timeout default", d, 16'h0FFF);
      rd(AD_STAT, d); chk("R1 status", d, 0);
      rst_n = 1'b1;
      idle(2);
      rd(AD_TMO, d);  chk("R1 timeout after release", d, 16'h0FFF);

      // R3 register width
      wr(AD_TMO, 16'h0123); rd(AD_TMO, d); chk("R3 readback", d, 16'h0123);
      wr(AD_TMO, 16'hFABC); rd(AD_TMO, d); chk("R3 upper bits dropped", d, 16'h0ABC);

      // R2 / R8 crossing behaviour
      send(16'sd5);
      chk("R2 first sample sets zx", zx, 1);
      rd(AD_STAT, d); chk("R2 first sample no crossing", d, 0);
      send(-16'sd3);
      chk("R2 falls on negative", zx, 0);
      chk("R8 masked irq", irq_n, 1);
      rd(AD_STAT, d); chk("R8 crossing flag", d, 1);
      wr(AD_IRQEN, 16'h0001);
      chk("R8 enabled irq", irq_n, 0);
      rd(AD_STAT, d);
      chk("R9 plain read keeps irq", irq_n, 0);
      rd(AD_STRC, d);
      chk("R9 clear read data", d, 1);
      chk("R9 irq released", irq_n, 1);
      rd(AD_STAT, d); chk("R9 flags cleared", d, 0);
      send(16'sd0);
      chk("R2 zero is positive", zx, 1);
      @(negedge clk); smp_data = -16'sd100; smp_valid = 1'b0;
      idle(3);
      chk("R2 invalid sample ignored", zx, 1);

      // R4 / R5 / R7 exact timeout with enabled interrupt
      wr(AD_IRQEN, 16'h0002);
      wr(AD_TMO, 16'd3);
      rd(AD_STRC, d);
      send(-16'sd1);
      idle(3*128 - 1);
      chk("R4 sag one cycle early", sag_n, 1);
      chk("R7 irq one cycle early", irq_n, 1);
      idle(1);
      chk("R4 sag at expiry", sag_n, 0);
      chk("R7 irq at expiry", irq_n, 0);
      idle(300);
      chk("R5 sag held", sag_n, 0);
      rd(AD_STAT, d); chk("R7 flag set", d[1], 1);
      send(16'sd7);
      chk("R5 crossing releases sag", sag_n, 1);

      // R7 masked timeout
      wr(AD_IRQEN, 16'h0000);
      wr(AD_TMO, 16'd1);
      rd(AD_STRC, d);
      send(-16'sd9);
      idle(128);
      chk("R4 N=1 expiry", sag_n, 0);
      chk("R7 masked irq", irq_n, 1);
      rd(AD_STAT, d); chk("R7 flag without enable", d[1], 1);

      // R6 sag disable
      wr(AD_CTRL, 16'h0001);
      wr(AD_TMO, 16'd2);
      rd(AD_STRC, d);
      send(16'sd9);
      idle(2*128 + 4);
      chk("R6 sag masked", sag_n, 1);
      rd(AD_STAT, d); chk("R6 flag still set", d[1], 1);
      wr(AD_CTRL, 16'h0000);
      chk("R6 unmask shows sag", sag_n, 0);

      // R4 restart mid-count
      send(-16'sd2);
      idle(200);
      send(16'sd2);
      idle(2*128 - 1);
      chk("R4 restart early", sag_n, 1);
      idle(1);
      chk("R4 restart expiry", sag_n, 0);

      // random stream, crossing flag model
      wr(AD_TMO, 16'h0FFF);
      rd(AD_STRC, d);
      exp_pol  = 1'b1;
      exp_xing = 1'b0;
      for (int i = 0; i < 400; i++) begin
         logic signed [15:0] v;
         logic vld;
         v   = 16'($urandom_range(0, 65535));
         if ($urandom_range(0, 9) == 0) v = '0;
         vld = ($urandom_range(0, 3) != 0);
         @(negedge clk);
         smp_valid = vld;
         smp_data  = v;
         if (vld) begin
            if (pol_of(v) != exp_pol) exp_xing = 1'b1;
            exp_pol = pol_of(v);
         end
         @(negedge clk);
         smp_valid = 1'b0;
         if (i % 40 == 0) chk("R2 random zx", zx, exp_pol);
      end
      chk("R2 random final zx", zx, exp_pol);
      rd(AD_STRC, d);
      chk("R8 random crossing flag", d[0], exp_xing);
      chk("R5 random no sag", sag_n, exp_xing ? 1 : 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule